// File: doc/BRIEF.md
# Bit-Slicing Serial Data Router

This block moves single bits from a bank of source words to a bank of destination words over one shared one-bit bus. It holds sixteen source words, set up as two groups of eight lanes, and sixteen destination words. In every cycle of a run, one source is chosen. The most significant bit of that source is driven onto the bus. The block latches that bit together with a destination index, and in the following cycle it shifts the bit into the chosen destination word at its least significant end.

A run covers one slot per source for every bit position of the word. The sixteen slots of one pass over the sources form a scan. After each scan, all source words shift left by one bit, which brings the next bit plane to the top. Each slot reads its source, its destination and its write permission from a sixteen-entry pattern table that software can rewrite. A destination can be fixed in the table, or it can follow the scan number. The table comes out of reset set up for a bit-plane transpose: destination j collects bit plane j of every source. A one-cycle completion pulse tells the user that the destination words are final.

Top module: `bitslice_router`

## Requirements
- R1: After reset all destination words read 0, `busy_o` and `done_o` are low and `bus_o` is 0.
- R2: A `start_i` sampled while idle loads the source words from `load_data_i`, where source k occupies bits [k*WORD_W +: WORD_W]. The run then takes one slot cycle per source per bit, so `done_o` rises exactly NUM_SRC*WORD_W+1 clock edges after the start edge.
- R3: With the reset table contents, the run leaves destination j with bit (WORD_W-1-k) equal to bit (WORD_W-1-j) of source k: a bit-plane transpose.
- R4: A source index of 4 bits uses its low 3 bits as the lane and bit 3 as the group (0 selects sources 0-7, 1 selects sources 8-15). At most one group drives the bus. `bus_o` equals the current MSB of the selected source during a run and 0 when no run is active.
- R5: A table entry in fixed mode shifts the bus bit into the destination named by its destination field, entering at bit 0. In scan mode the destination is the scan number modulo NUM_DST.
- R6: A destination word changes only in the cycle after a slot whose entry has write permission addresses it. Entries without write permission leave every destination word unchanged.
- R7: The source words shift left by one bit, filling with 0, once at the end of every scan of NUM_SRC slots.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The source words and the result of the run in progress are not affected.
- R9: `done_o` is high for exactly one cycle. In that cycle `busy_o` is low and the destination words hold the final result.
- R10: When `pat_we_i` is high, the entry at `pat_addr_i` takes the values on `pat_src_i`, `pat_dst_i`, `pat_by_scan_i` (1 = scan mode) and `pat_wr_en_i` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load source words and begin a run |
| load_data_i | input | NUM_SRC*WORD_W | Source words, source k at [k*WORD_W +: WORD_W] |
| pat_we_i | input | 1 | Pattern table write strobe |
| pat_addr_i | input | SLOT_W | Slot entry to write |
| pat_src_i | input | SRC_W | Source index for the slot |
| pat_dst_i | input | DST_W | Fixed destination index for the slot |
| pat_by_scan_i | input | 1 | 1: destination follows the scan number |
| pat_wr_en_i | input | 1 | 1: the slot writes its destination |
| busy_o | output | 1 | Run or final write in progress |
| done_o | output | 1 | One-cycle pulse when the result is final |
| bus_o | output | 1 | Shared bit bus |
| dst_data_o | output | NUM_DST*WORD_W | Destination words, word d at [d*WORD_W +: WORD_W] |

## Verification
The bench builds the block with its default parameters: two groups of eight lanes, 16-bit words and sixteen destinations. With these values the source count equals the word width, so the reset table gives a square transpose, and scan mode reaches every destination. Slots in both groups are observed on the bus. A reprogrammed table with reversed sources, four fixed destinations and one write-disabled slot reaches destination words that wrap past their width, as well as words that must keep earlier results.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic {
    DST_FIXED   = 1'b0,
    DST_BY_SCAN = 1'b1
  } dst_mode_e;
endpackage

// File: rtl/bsr_seq.sv
module bsr_seq #(
  parameter int SLOTS  = 16,
  parameter int WORD_W = 16,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int SCAN_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hold_i,
  output logic              load_o,
  output logic              run_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SCAN_W-1:0] scan_o,
  output logic              shift_o,
  output logic              last_o
);
  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SCAN_W-1:0] scan_q;

  assign load_o  = start_i & ~run_q & ~hold_i;
  assign shift_o = run_q & (slot_q == SLOT_W'(SLOTS - 1));
  assign last_o  = shift_o & (scan_q == SCAN_W'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      scan_q <= '0;
    end else if (load_o) begin
      run_q  <= 1'b1;
      slot_q <= '0;
      scan_q <= '0;
    end else if (run_q) begin
      if (shift_o) begin
        slot_q <= '0;
        scan_q <= scan_q + 1'b1;
        if (last_o) run_q <= 1'b0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign run_o  = run_q;
  assign slot_o = slot_q;
  assign scan_o = scan_q;

  assert_run_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !run_o);
  assert_run_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !last_o) |=> run_o);
  assert_scan_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && !last_o) |=> (slot_o == '0) && (scan_o == $past(scan_o) + 1'b1));
endmodule

// File: rtl/bsr_pat_table.sv
module bsr_pat_table #(
  parameter int SLOTS   = 16,
  parameter int NUM_DST = 16,
  parameter int SRC_W   = 4,
  parameter int DST_W   = $clog2(NUM_DST),
  parameter int SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] waddr_i,
  input  logic [SRC_W-1:0]  wsrc_i,
  input  logic [DST_W-1:0]  wdst_i,
  input  logic              wscan_i,
  input  logic              wwr_i,
  input  logic [SLOT_W-1:0] raddr_i,
  output logic [SRC_W-1:0]  rsrc_o,
  output logic [DST_W-1:0]  rdst_o,
  output logic              rscan_o,
  output logic              rwr_o
);
  localparam int ENT_W = SRC_W + DST_W + 2;

  logic [SLOTS-1:0][ENT_W-1:0] ent_q;
  logic [ENT_W-1:0]            rd_ent;

  // reset contents: slot k reads source k, destination follows the scan
  function automatic logic [ENT_W-1:0] dflt_ent(input int k);
    return {1'b1, 1'b1, DST_W'(k % NUM_DST), SRC_W'(k)};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < SLOTS; k++) ent_q[k] <= dflt_ent(k);
    end else if (we_i) begin
      ent_q[waddr_i] <= {wwr_i, wscan_i, wdst_i, wsrc_i};
    end
  end

  assign rd_ent  = ent_q[raddr_i];
  assign rsrc_o  = rd_ent[SRC_W-1:0];
  assign rdst_o  = rd_ent[SRC_W +: DST_W];
  assign rscan_o = rd_ent[SRC_W+DST_W];
  assign rwr_o   = rd_ent[ENT_W-1];

  assert_tbl_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ent_q[$past(waddr_i)] == $past({wwr_i, wscan_i, wdst_i, wsrc_i}));
endmodule

// File: rtl/bsr_src_bank.sv
module bsr_src_bank #(
  parameter int LANES   = 8,
  parameter int GROUPS  = 2,
  parameter int WORD_W  = 16,
  parameter int NUM_SRC = LANES * GROUPS,
  parameter int LANE_W  = $clog2(LANES),
  parameter int GRP_W   = $clog2(GROUPS),
  parameter int SRC_W   = LANE_W + GRP_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [NUM_SRC*WORD_W-1:0] load_data_i,
  input  logic                      shift_i,
  input  logic                      sel_en_i,
  input  logic [SRC_W-1:0]          sel_i,
  output logic                      bus_o
);
  logic [NUM_SRC-1:0][WORD_W-1:0] src_q;
  logic [NUM_SRC-1:0]             msb_v;
  logic [GROUPS-1:0]              grp_en;
  logic [GROUPS-1:0]              grp_bit;
  logic [LANE_W-1:0]              lane_idx;
  logic [GRP_W-1:0]               grp_idx;

  assign lane_idx = sel_i[LANE_W-1:0];
  assign grp_idx  = sel_i[SRC_W-1 -: GRP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
    end else if (load_i) begin
      src_q <= load_data_i;
    end else if (shift_i) begin
      for (int i = 0; i < NUM_SRC; i++) src_q[i] <= {src_q[i][WORD_W-2:0], 1'b0};
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_msb
    assign msb_v[i] = src_q[i][WORD_W-1];
  end

  // one 8-way selector per group; the disabled group contributes 0
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [LANES-1:0] grp_msb;
    assign grp_msb    = msb_v[g*LANES +: LANES];
    assign grp_en[g]  = sel_en_i & (grp_idx == GRP_W'(g));
    assign grp_bit[g] = grp_en[g] & grp_msb[lane_idx];
  end

  assign bus_o = |grp_bit;

  assert_one_driver_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_en));
  assert_src_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(src_q));
  assert_src_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> src_q[0] == {$past(src_q[0][WORD_W-2:0]), 1'b0});
endmodule

// File: rtl/bsr_dist_bank.sv
module bsr_dist_bank #(
  parameter int NUM_DST = 16,
  parameter int WORD_W  = 16,
  parameter int DST_W   = $clog2(NUM_DST)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      stb_i,
  input  logic [DST_W-1:0]          addr_i,
  input  logic                      bit_i,
  output logic                      pend_o,
  output logic [NUM_DST*WORD_W-1:0] data_o
);
  logic                           stb_q;
  logic [DST_W-1:0]               addr_q;
  logic                           bit_q;
  logic [NUM_DST-1:0]             wr_v;
  logic [NUM_DST-1:0][WORD_W-1:0] dst_q;

  // strobe latches address and bus bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      addr_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      stb_q <= stb_i;
      if (stb_i) begin
        addr_q <= addr_i;
        bit_q  <= bit_i;
      end
    end
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    assign wr_v[d] = stb_q & (addr_q == DST_W'(d));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dst_q[d] <= '0;
      else if (wr_v[d]) dst_q[d] <= {dst_q[d][WORD_W-2:0], bit_q};
    end
  end

  assign pend_o = stb_q;
  assign data_o = dst_q;

  assert_one_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_v));
  assert_dst_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_q |=> $stable(dst_q));
  assert_dst_lsb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> dst_q[$past(addr_q)][0] == $past(bit_q));
endmodule

// File: rtl/bitslice_router.sv
module bitslice_router
  import bsr_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int GROUPS  = 2,
  parameter int WORD_W  = 16,
  parameter int NUM_DST = 16,
  localparam int NUM_SRC = LANES * GROUPS,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int DST_W   = $clog2(NUM_DST),
  localparam int SLOT_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [NUM_SRC*WORD_W-1:0] load_data_i,
  input  logic                      pat_we_i,
  input  logic [SLOT_W-1:0]         pat_addr_i,
  input  logic [SRC_W-1:0]          pat_src_i,
  input  logic [DST_W-1:0]          pat_dst_i,
  input  logic                      pat_by_scan_i,
  input  logic                      pat_wr_en_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      bus_o,
  output logic [NUM_DST*WORD_W-1:0] dst_data_o
);
  localparam int SCAN_W = $clog2(WORD_W);

  logic              load, run, shift, last;
  logic [SLOT_W-1:0] slot;
  logic [SCAN_W-1:0] scan;
  logic [SRC_W-1:0]  ent_src;
  logic [DST_W-1:0]  ent_dst, dst_sel;
  logic              ent_scan, ent_wr;
  logic              bus, pend, last_q, done_q;
  dst_mode_e         mode;

  bsr_seq #(.SLOTS(NUM_SRC), .WORD_W(WORD_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .hold_i(pend),
    .load_o(load), .run_o(run), .slot_o(slot), .scan_o(scan),
    .shift_o(shift), .last_o(last)
  );

  bsr_pat_table #(.SLOTS(NUM_SRC), .NUM_DST(NUM_DST), .SRC_W(SRC_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(pat_we_i), .waddr_i(pat_addr_i), .wsrc_i(pat_src_i),
    .wdst_i(pat_dst_i), .wscan_i(pat_by_scan_i), .wwr_i(pat_wr_en_i),
    .raddr_i(slot), .rsrc_o(ent_src), .rdst_o(ent_dst),
    .rscan_o(ent_scan), .rwr_o(ent_wr)
  );

  bsr_src_bank #(.LANES(LANES), .GROUPS(GROUPS), .WORD_W(WORD_W)) u_src (
    .clk_i, .rst_ni, .load_i(load), .load_data_i, .shift_i(shift),
    .sel_en_i(run), .sel_i(ent_src), .bus_o(bus)
  );

  assign mode    = dst_mode_e'(ent_scan);
  assign dst_sel = (mode == DST_BY_SCAN) ? DST_W'(scan % NUM_DST) : ent_dst;

  bsr_dist_bank #(.NUM_DST(NUM_DST), .WORD_W(WORD_W)) u_dist (
    .clk_i, .rst_ni, .stb_i(run & ent_wr), .addr_i(dst_sel), .bit_i(bus),
    .pend_o(), .data_o(dst_data_o)
  );

  // trailing write cycle tracked here so a write-disabled last slot still ends cleanly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend   <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend   <= run;
      last_q <= last;
      done_q <= last_q;
    end
  end

  assign busy_o = run | pend;
  assign done_o = done_q;
  assign bus_o  = bus;

  assert_bus_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !bus_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !last) |=> busy_o);
endmodule

// File: tb/bitslice_router_tb_top.sv
`timescale 1ns/1ps
module bitslice_router_tb_top;
  localparam int W   = 16;
  localparam int NS  = 16;
  localparam int ND  = 16;
  localparam int RUN_EDGES = NS * W + 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [NS*W-1:0] load_data_i = '0;
  logic            pat_we_i = 1'b0;
  logic [3:0]      pat_addr_i = '0;
  logic [3:0]      pat_src_i = '0;
  logic [3:0]      pat_dst_i = '0;
  logic            pat_by_scan_i = 1'b0;
  logic            pat_wr_en_i = 1'b0;
  logic            busy_o, done_o, bus_o;
  logic [ND*W-1:0] dst_data_o;

  always #10 clk_i = ~clk_i;

  bitslice_router #(.LANES(8), .GROUPS(2), .WORD_W(W), .NUM_DST(ND)) dut_i (.*);

  typedef struct {
    int         idx;
    logic [W-1:0] word;
    string      req;
  } item_t;

  item_t        sb_q[$];
  int           total = 0;
  int           bad = 0;
  logic [W-1:0] stim[NS];
  logic [W-1:0] mdl_in[NS];
  logic [W-1:0] mdl_out[ND];
  int           tb_src[NS];
  int           tb_dst[NS];
  bit           tb_scan[NS];
  bit           tb_wr[NS];
  string        tag_lo, tag_hi;
  int           tag_split;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // scoreboard monitor: compare queued expectations when the result is flagged final
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        for (int d = 0; d < ND; d++) begin
          if (sb_q.size() == 0) begin
            check("R9", "unexpected done", 32'd1, 32'd0);
          end else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, $sformatf("dst %0d", it.idx),
                  32'(dst_data_o[it.idx*W +: W]), 32'(it.word));
          end
        end
      end
    end
  end

  // behaviour model of one run from the requirements
  task automatic model_run();
    for (int k = 0; k < NS; k++) mdl_in[k] = stim[k];
    for (int j = 0; j < W; j++) begin
      for (int k = 0; k < NS; k++) begin
        logic b;
        int   dd;
        b = mdl_in[tb_src[k]][W-1];
        if (tb_wr[k]) begin
          dd = tb_scan[k] ? (j % ND) : tb_dst[k];
          mdl_out[dd] = {mdl_out[dd][W-2:0], b};
        end
      end
      for (int k = 0; k < NS; k++) mdl_in[k] = mdl_in[k] << 1;
    end
  endtask

  task automatic prog(input int k, input int s, input int d, input bit sc, input bit wr);
    @(negedge clk_i);
    pat_we_i = 1'b1; pat_addr_i = 4'(k); pat_src_i = 4'(s);
    pat_dst_i = 4'(d); pat_by_scan_i = sc; pat_wr_en_i = wr;
    @(negedge clk_i);
    pat_we_i = 1'b0;
    tb_src[k] = s; tb_dst[k] = d; tb_scan[k] = sc; tb_wr[k] = wr;
  endtask

  // driver: push expected words, start, follow the run
  task automatic run_word(input bit poke);
    int n;
    model_run();
    for (int d = 0; d < ND; d++)
      sb_q.push_back('{d, mdl_out[d], (d < tag_split) ? tag_lo : tag_hi});
    @(negedge clk_i);
    for (int k = 0; k < NS; k++) load_data_i[k*W +: W] = stim[k];
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    check("R4", "bus slot 0 (group 0)", 32'(bus_o), 32'(stim[tb_src[0]][W-1]));
    check("R2", "busy after start", 32'(busy_o), 32'd1);
    while (!done_o && n < 2000) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (n == 8)
        check("R4", "bus slot 8 (group 1)", 32'(bus_o), 32'(stim[tb_src[8]][W-1]));
      if (poke && n == 100) begin
        load_data_i = ~load_data_i;
        start_i = 1'b1;
      end
      if (poke && n == 101) start_i = 1'b0;
    end
    check("R2", "edges start to done", 32'(n), 32'(RUN_EDGES));
    check("R9", "busy low with done", 32'(busy_o), 32'd0);
    @(negedge clk_i);
    check("R9", "done one cycle", 32'(done_o), 32'd0);
    check("R4", "bus idle zero", 32'(bus_o), 32'd0);
  endtask

  initial begin
    #(20.0 * 200000);
    check("R2", "watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    for (int k = 0; k < NS; k++) begin
      tb_src[k] = k; tb_dst[k] = k % ND; tb_scan[k] = 1'b1; tb_wr[k] = 1'b1;
    end
    for (int d = 0; d < ND; d++) mdl_out[d] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "dst words", 32'(|dst_data_o), 32'd0);
    check("R1", "busy", 32'(busy_o), 32'd0);
    check("R1", "done", 32'(done_o), 32'd0);
    check("R1", "bus", 32'(bus_o), 32'd0);

    // R3 R7: default transpose, mixed data
    tag_lo = "R3 R7"; tag_hi = "R3 R7"; tag_split = ND;
    for (int k = 0; k < NS; k++) stim[k] = 16'hA5C3 ^ 16'(k * 16'h1357) ^ 16'(k << 12);
    run_word(1'b0);
    // cross-check the transpose relation directly
    for (int k = 0; k < NS; k += 5)
      check("R3", $sformatf("transpose bit src %0d", k),
            32'(dst_data_o[3*W + (W-1-k)]), 32'(stim[k][W-1-3]));

    // R3 R8: walking-one data, restart attempted mid-run
    tag_lo = "R3 R8"; tag_hi = "R3 R8";
    for (int k = 0; k < NS; k++) stim[k] = 16'h0001 << k;
    run_word(1'b1);

    // R5 R10 R6: reversed sources, four fixed destinations, slot 5 disabled
    for (int k = 0; k < NS; k++) prog(k, NS-1-k, k % 4, 1'b0, (k != 5));
    tag_lo = "R5 R10"; tag_hi = "R6"; tag_split = 4;
    for (int k = 0; k < NS; k++) stim[k] = 16'h3C96 + 16'(k * 16'h0B0D);
    run_word(1'b0);

    // R6: all slots write-disabled, every destination keeps its word
    for (int k = 0; k < NS; k++) prog(k, k, k, 1'b1, 1'b0);
    tag_lo = "R6"; tag_hi = "R6"; tag_split = ND;
    for (int k = 0; k < NS; k++) stim[k] = 16'hFFFF;
    run_word(1'b0);

    repeat (3) @(negedge clk_i);
    check("R9", "scoreboard drained", 32'(sb_q.size()), 32'd0);
    finish_run();
  end
endmodule